// File: doc/BRIEF.md
# Page Buffer Program Sequencer

This block handles the write side of a byte-wide, page-programmable nonvolatile memory. Byte loads arrive as single-cycle strobes, each with a 15-bit address and an 8-bit data value. They are gathered into a 64-byte page buffer. A load window opens with the first load. It closes by itself once a set number of cycles pass with no accepted load. Closing the window starts a timed program cycle.

During the first 64 cycles of the program cycle, the block writes every byte of the page into an external behavioural storage array. Bytes that were loaded get their data. Bytes that were not loaded get a fixed fill value. For the whole program cycle the block reports busy. Reads during that time return a status byte instead of array data. The host polls this status in one of two ways: bit 7 carries the complement of bit 7 of the most recent loaded byte, and bit 6 flips on every read.

Outside the program cycle, reads return the storage array's data for the requested address. All durations are parameters counted in clock cycles.

Top module: `page_prog_seq`

## Requirements
- R1: After reset, busy, page_err, arr_we and rd_data are all 0.
- R2: Address bits 14..6 give the page and bits 5..0 give the byte offset. Loads within one page may come in any order. A byte loaded twice keeps its latest data, and each byte ends up at its own offset of the page.
- R3: The window closes when WIN_CYC consecutive clock cycles pass with no accepted load. busy rises in the cycle after the WIN_CYC-th such cycle. A load accepted on any earlier cycle restarts the count.
- R4: busy stays high for exactly PROG_CYC cycles, then drops.
- R5: During the first 64 busy cycles, arr_we is 1 and arr_addr is {page, index}, with the index counting up from 0. arr_wdata is the loaded byte for that index, or FILL (0xFF) if the byte was not loaded. arr_we is 0 at all other times.
- R6: A load in an open window whose page differs from the window's first load is ignored and sets page_err. page_err stays 1 until reset.
- R7: Loads that arrive while busy is 1 are ignored.
- R8: A read while not busy returns arr_rdata for rd_addr on rd_data in the next cycle.
- R9: A read while busy returns a status byte in the next cycle. Its bit 7 is the inverse of bit 7 of the last accepted load, and its bits 5..0 are 0.
- R10: Bit 6 of the status inverts on every busy read, and the first busy read after reset returns 1. Reads while not busy leave this bit's state unchanged.
- R11: Reset clears the loaded marks of the buffer, the timers and the toggle. Bytes loaded before a reset are programmed as FILL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | Byte load strobe |
| ld_addr | input | 15 | Byte load address (page, offset) |
| ld_data | input | 8 | Byte load data |
| rd_valid | input | 1 | Read request |
| rd_addr | input | 15 | Read address, also presented to the array |
| arr_rdata | input | 8 | Array data for rd_addr |
| rd_data | output | 8 | Read result, one cycle after the request |
| busy | output | 1 | Program cycle running |
| page_err | output | 1 | Sticky flag for a load with the wrong page |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | 15 | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
The first pattern loads one page out of order, loads one offset twice, and leaves gaps shorter than the timeout. It shows whether the offset is decoded correctly, whether the latest data wins, and whether unloaded bytes get the fill value. A second load placed on the very last cycle of the window separates a correct timeout from one that is off by one. Loads and reads issued during the program cycle show that stray loads are dropped and that status alternates, while reads after the cycle show the toggle is frozen. A load from a foreign page and a reset in the middle of a window show that the error flag is sticky and that a reset discards what was already loaded.

// File: rtl/pps_pkg.sv
package pps_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } pps_state_e;
endpackage

// File: rtl/pps_seq.sv
module pps_seq
    import pps_pkg::*;
#(
    parameter int PAGE_W     = 9,
    parameter int OFF_W      = 6,
    parameter int WIN_CYC    = 15000,
    parameter int PROG_CYC   = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [PAGE_W-1:0] ld_page,
    output logic              accept,
    output logic              done,
    output logic              busy,
    output logic              page_err,
    output logic              we,
    output logic [OFF_W-1:0]  wr_idx,
    output logic [PAGE_W-1:0] page
);
    localparam int PAGE_BYTES = 1 << OFF_W;
    localparam int CNT_MAX    = (WIN_CYC > PROG_CYC) ? WIN_CYC : PROG_CYC;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);

    typedef struct packed {
        pps_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [PAGE_W-1:0] page;
        logic              err;
    } seq_s;

    seq_s seq_d, seq_q;

    always_comb begin
        seq_d  = seq_q;
        accept = 1'b0;
        done   = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (ld_valid) begin
                    accept     = 1'b1;
                    seq_d.page = ld_page;
                    seq_d.st   = ST_LOAD;
                    seq_d.cnt  = '0;
                end
            end
            ST_LOAD: begin
                if (ld_valid && (ld_page == seq_q.page)) begin
                    accept    = 1'b1;
                    seq_d.cnt = '0;
                end else begin
                    if (ld_valid) seq_d.err = 1'b1;
                    if (seq_q.cnt == CNT_W'(WIN_CYC - 1)) begin
                        seq_d.st  = ST_PROG;
                        seq_d.cnt = '0;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
            end
            ST_PROG: begin
                if (seq_q.cnt == CNT_W'(PROG_CYC - 1)) begin
                    done      = 1'b1;
                    seq_d.st  = ST_IDLE;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, cnt: '0, page: '0, err: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy     = (seq_q.st == ST_PROG);
    assign we       = busy && (seq_q.cnt < CNT_W'(PAGE_BYTES));
    assign wr_idx   = seq_q.cnt[OFF_W-1:0];
    assign page     = seq_q.page;
    assign page_err = seq_q.err;

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        page_err |=> page_err);
    p_write_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (we && (wr_idx == '0)));
    p_busy_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));
    p_no_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ld_valid) |=> (page == $past(page)));
endmodule

// File: rtl/pps_load_buf.sv
module pps_load_buf #(
    parameter int          OFF_W  = 6,
    parameter int          DATA_W = 8,
    parameter logic [7:0]  FILL   = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              clear,
    input  logic              busy,
    input  logic [OFF_W-1:0]  ld_off,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [OFF_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_byte,
    output logic              last_msb
);
    localparam int PAGE_BYTES = 1 << OFF_W;

    typedef struct packed {
        logic [PAGE_BYTES-1:0]             vld;
        logic [PAGE_BYTES-1:0][DATA_W-1:0] dat;
        logic [DATA_W-1:0]                 last;
    } buf_s;

    buf_s buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (clear) begin
            buf_d.vld = '0;
        end else if (accept) begin
            buf_d.vld[ld_off] = 1'b1;
            buf_d.dat[ld_off] = ld_data;
            buf_d.last        = ld_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    assign rd_byte  = buf_q.vld[rd_idx] ? buf_q.dat[rd_idx] : DATA_W'(FILL);
    assign last_msb = buf_q.last[DATA_W-1];

    p_buf_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !clear) |=> $stable(buf_q.vld));
    p_clear_after_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (buf_q.vld == '0));
endmodule

// File: rtl/pps_status.sv
module pps_status #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic              busy,
    input  logic              last_msb,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic [DATA_W-1:0] rd;
        logic              tog;
    } st_s;

    st_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_valid) begin
            if (busy) begin
                st_d.tog            = ~st_q.tog;
                st_d.rd             = '0;
                st_d.rd[DATA_W-1]   = ~last_msb;
                st_d.rd[DATA_W-2]   = ~st_q.tog;
            end else begin
                st_d.rd = arr_rdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rd;

    p_tog_flip_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && busy) |=> (st_q.tog != $past(st_q.tog)));
    p_tog_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && busy) |=> $stable(st_q.tog));
    p_poll_msb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && busy) |=> (rd_data[DATA_W-1] == !$past(last_msb)));
endmodule

// File: rtl/page_prog_seq.sv
module page_prog_seq #(
    parameter int         ADDR_W   = 15,
    parameter int         OFF_W    = 6,
    parameter int         DATA_W   = 8,
    parameter int         WIN_CYC  = 15000,
    parameter int         PROG_CYC = 1000000,
    parameter logic [7:0] FILL     = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              page_err,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata
);
    localparam int PAGE_W = ADDR_W - OFF_W;

    logic              accept;
    logic              done;
    logic [OFF_W-1:0]  wr_idx;
    logic [PAGE_W-1:0] page;
    logic              last_msb;
    logic              rd_unused;

    assign rd_unused = ^rd_addr;

    pps_seq #(
        .PAGE_W   (PAGE_W),
        .OFF_W    (OFF_W),
        .WIN_CYC  (WIN_CYC),
        .PROG_CYC (PROG_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_valid (ld_valid),
        .ld_page  (ld_addr[ADDR_W-1:OFF_W]),
        .accept   (accept),
        .done     (done),
        .busy     (busy),
        .page_err (page_err),
        .we       (arr_we),
        .wr_idx   (wr_idx),
        .page     (page)
    );

    pps_load_buf #(
        .OFF_W  (OFF_W),
        .DATA_W (DATA_W),
        .FILL   (FILL)
    ) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .clear    (done),
        .busy     (busy),
        .ld_off   (ld_addr[OFF_W-1:0]),
        .ld_data  (ld_data),
        .rd_idx   (wr_idx),
        .rd_byte  (arr_wdata),
        .last_msb (last_msb)
    );

    pps_status #(
        .DATA_W (DATA_W)
    ) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_valid  (rd_valid),
        .busy      (busy),
        .last_msb  (last_msb),
        .arr_rdata (arr_rdata),
        .rd_data   (rd_data)
    );

    assign arr_addr = {page, wr_idx};

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);
endmodule

// File: tb/page_prog_seq_bench.sv
module page_prog_seq_bench;
    localparam int WIN  = 20;
    localparam int PROG = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [14:0] ld_addr = '0;
    logic [7:0]  ld_data = '0;
    logic        rd_valid = 1'b0;
    logic [14:0] rd_addr = '0;
    logic [7:0]  arr_rdata;
    logic [7:0]  rd_data;
    logic        busy, page_err, arr_we;
    logic [14:0] arr_addr;
    logic [7:0]  arr_wdata;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    page_prog_seq #(.WIN_CYC(WIN), .PROG_CYC(PROG)) u_page_prog_seq (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
        .ld_data(ld_data), .rd_valid(rd_valid), .rd_addr(rd_addr),
        .arr_rdata(arr_rdata), .rd_data(rd_data), .busy(busy),
        .page_err(page_err), .arr_we(arr_we), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata)
    );

    // storage array for pages 0..3
    logic [7:0] mem [256];
    logic [7:0] m_mem [256];
    initial for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; m_mem[i] = 8'h00; end
    always @(posedge clk) if (arr_we) mem[arr_addr[7:0]] <= arr_wdata;
    assign arr_rdata = mem[rd_addr[7:0]];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int         m_st, m_cnt;
    logic [8:0] m_page;
    bit         m_vld [64];
    logic [7:0] m_buf [64];
    logic [7:0] m_last, m_rd;
    bit         m_tog, m_err;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_page = '0; m_last = '0; m_rd = '0;
            m_tog = 0; m_err = 0;
            for (int i = 0; i < 64; i++) m_vld[i] = 0;
        end else begin
            if (rd_valid) begin
                if (m_st == 2) begin
                    m_tog = !m_tog;
                    m_rd = {~m_last[7], m_tog, 6'b0};
                end else m_rd = mem[rd_addr[7:0]];
            end
            case (m_st)
                0: if (ld_valid) begin
                    m_page = ld_addr[14:6];
                    m_buf[ld_addr[5:0]] = ld_data; m_vld[ld_addr[5:0]] = 1;
                    m_last = ld_data; m_st = 1; m_cnt = 0;
                end
                1: if (ld_valid && ld_addr[14:6] == m_page) begin
                    m_buf[ld_addr[5:0]] = ld_data; m_vld[ld_addr[5:0]] = 1;
                    m_last = ld_data; m_cnt = 0;
                end else begin
                    if (ld_valid) m_err = 1;
                    if (m_cnt == WIN - 1) begin m_st = 2; m_cnt = 0; end
                    else m_cnt++;
                end
                default: begin
                    if (m_cnt < 64)
                        m_mem[{m_page[1:0], m_cnt[5:0]}] = m_vld[m_cnt] ? m_buf[m_cnt] : 8'hFF;
                    if (m_cnt == PROG - 1) begin
                        m_st = 0; m_cnt = 0;
                        for (int i = 0; i < 64; i++) m_vld[i] = 0;
                    end else m_cnt++;
                end
            endcase
        end
    end

    // per-cycle comparison
    always @(negedge clk) if (rst_n) begin
        chk(busy == (m_st == 2), "R4 busy", busy, m_st == 2);
        chk(page_err == m_err, "R6 page_err", page_err, m_err);
        chk(rd_data == m_rd, "R8/R9 rd_data", rd_data, m_rd);
        chk(arr_we == (m_st == 2 && m_cnt < 64), "R5 arr_we", arr_we, m_st == 2 && m_cnt < 64);
        if (arr_we && m_st == 2 && m_cnt < 64) begin
            chk(arr_addr == {m_page, m_cnt[5:0]}, "R5 arr_addr", arr_addr, {m_page, m_cnt[5:0]});
            chk(arr_wdata == (m_vld[m_cnt] ? m_buf[m_cnt] : 8'hFF), "R5 arr_wdata",
                arr_wdata, m_vld[m_cnt] ? m_buf[m_cnt] : 8'hFF);
        end
    end

    function automatic logic [14:0] ad(input int pg, input int off);
        return 15'(pg * 64 + off);
    endfunction

    task automatic load(input logic [14:0] a, input logic [7:0] d);
        ld_valid = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic rd(input logic [14:0] a, input logic [7:0] exp, input string tag);
        rd_valid = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_valid = 1'b0;
        chk(rd_data == exp, tag, rd_data, exp);
    endtask

    task automatic wait_busy;
        for (int i = 0; i < 1000 && !busy; i++) @(negedge clk);
    endtask

    task automatic wait_idle;
        wait_busy();
        for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        int n, m;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && page_err == 0 && arr_we == 0 && rd_data == 0, "R1 reset state",
            {busy, page_err, arr_we, rd_data}, 0);

        // out-of-order page load with a reloaded offset
        load(ad(1, 10), 8'h3C); repeat (5) @(negedge clk);
        load(ad(1, 63), 8'h81); repeat (3) @(negedge clk);
        load(ad(1, 3), 8'h11);
        load(ad(1, 3), 8'h5A);
        n = 0;
        while (!busy && n < 1000) begin @(negedge clk); n++; end
        chk(n == WIN, "R3 window timeout", n, WIN);
        m = 0;
        while (busy && m < 1000) begin @(negedge clk); m++; end
        chk(m == PROG, "R4 busy length", m, PROG);
        chk(mem[ad(1, 10)] == 8'h3C, "R2 offset 10", mem[ad(1, 10)], 8'h3C);
        chk(mem[ad(1, 63)] == 8'h81, "R2 offset 63", mem[ad(1, 63)], 8'h81);
        chk(mem[ad(1, 3)] == 8'h5A, "R2 reload wins", mem[ad(1, 3)], 8'h5A);
        chk(mem[ad(1, 0)] == 8'hFF, "R5 fill offset 0", mem[ad(1, 0)], 8'hFF);
        chk(mem[ad(1, 20)] == 8'hFF, "R5 fill offset 20", mem[ad(1, 20)], 8'hFF);

        // polling while busy, stray load while busy
        load(ad(2, 0), 8'hC7);
        wait_busy();
        rd(ad(2, 0), 8'h40, "R9 R10 first poll");
        rd(ad(2, 0), 8'h00, "R10 second poll");
        rd(ad(2, 0), 8'h40, "R10 third poll");
        load(ad(2, 5), 8'h77);
        wait_idle();
        chk(mem[ad(2, 5)] == 8'hFF, "R7 busy load ignored", mem[ad(2, 5)], 8'hFF);
        chk(mem[ad(2, 0)] == 8'hC7, "R2 page 2 byte", mem[ad(2, 0)], 8'hC7);
        rd(ad(2, 0), 8'hC7, "R8 read after cycle");
        rd(ad(1, 63), 8'h81, "R8 read other page");

        // foreign-page load
        load(ad(3, 1), 8'h22);
        load(ad(0, 2), 8'h33);
        chk(page_err == 1, "R6 err set", page_err, 1);
        wait_idle();
        chk(mem[ad(0, 2)] == 8'h00, "R6 foreign byte dropped", mem[ad(0, 2)], 8'h00);
        chk(mem[ad(3, 1)] == 8'h22, "R6 window page kept", mem[ad(3, 1)], 8'h22);
        chk(page_err == 1, "R6 err sticky", page_err, 1);

        // load on the last cycle of the window
        load(ad(0, 4), 8'h44);
        repeat (WIN - 1) @(negedge clk);
        chk(busy == 0, "R3 window still open", busy, 0);
        load(ad(0, 9), 8'h99);
        wait_idle();
        chk(mem[ad(0, 9)] == 8'h99, "R3 late load accepted", mem[ad(0, 9)], 8'h99);
        chk(mem[ad(0, 4)] == 8'h44, "R3 first load kept", mem[ad(0, 4)], 8'h44);
        rd(ad(2, 0), 8'hC7, "R10 toggle frozen, idle read");
        load(ad(2, 1), 8'h01);
        wait_busy();
        rd(ad(2, 1), 8'h80, "R10 toggle resumed, R9 msb");

        // reset in the middle of a window
        wait_idle();
        load(ad(0, 7), 8'hE0);
        do_reset();
        @(negedge clk);
        chk(busy == 0 && page_err == 0 && rd_data == 0, "R1 R11 after reset",
            {busy, page_err, rd_data}, 0);
        load(ad(0, 8), 8'h88);
        wait_idle();
        chk(mem[ad(0, 7)] == 8'hFF, "R11 pre-reset byte dropped", mem[ad(0, 7)], 8'hFF);
        chk(mem[ad(0, 8)] == 8'h88, "R11 new byte", mem[ad(0, 8)], 8'h88);

        for (int i = 0; i < 256; i++)
            chk(mem[i] == m_mem[i], "R2 array image", mem[i], m_mem[i]);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule